// File: doc/BRIEF.md
# Time-Redundant Route and Allocation Stage

This block controls the router pipeline stage that picks a flit's next output port and the switch-allocation grant. It does not trust a single evaluation. The stage evaluates both functions on a flit once. In the next cycle it evaluates them again on the same held flit and compares each second result with the first. If both pairs agree, the first results go to the crossbar. Detection therefore costs one extra cycle per flit.

When a pair disagrees, the stage stays busy for one more recovery cycle. In that cycle it evaluates the functions a third time. A function that disagreed takes the bitwise two-of-three majority of its three results. A function that agreed keeps its first result. The next-port and grant results are then released to the crossbar stage with a one-cycle enable pulse.

The route and allocation logic is modelled by simple combinational functions. Each has an XOR error-injection hook that flips result bits in whatever cycle the hook is driven. The stall output tells the buffer-write stage that the current head flit is not taken. It also holds the crossbar stage while the compare or recovery cycle is in progress.

Top module: `dual_eval_route_stage`

## Requirements
- R1: After reset, stall, xbarEn, outNp and outGrant are all 0.
- R2: A flit is accepted when flitValid is 1 and stall is 0. In the cycle after acceptance, stall is 1 (compare cycle).
- R3: If both result pairs agree, xbarEn is 1 exactly two cycles after acceptance. It carries the first-computed next port and grant, and stall is 0 in that cycle.
- R4: If either pair disagrees, stall stays 1 for a second cycle. xbarEn then rises three cycles after acceptance, and stall is never 1 for more than two cycles in a row.
- R5: Flipping one bit in any one of the three evaluations of a function yields a final value equal to the fault-free value, through the bitwise majority.
- R6: A function whose two results agreed is not voted. Its output is its first result, even if its third evaluation is corrupted.
- R7: With flitValid at 0 and the stage idle, stall and xbarEn remain 0.
- R8: flitValid, header, request and injection inputs present while stall is 1 do not start a new flit and do not change the pending flit's result. Injection masks applied while the stage is idle have no effect.
- R9: Next-port codes are local=0, north=1, east=2, south=3, west=4, up=5, down=6. The header is {dz,dy,dx}, two bits each, where 01 means plus, 10 means minus and other values mean none. X is resolved first (plus east, minus west), then Y (plus north, minus south), then Z (plus up, minus down), else local.
- R10: outGrant is one-hot on the lowest-index asserted bit of the 7-bit request vector, or 0 when no bit is set.
- R11: A new flit can be accepted in the same cycle that xbarEn is high for the previous flit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flitValid | input | 1 | Head flit from the buffer-write stage is valid |
| flitHdr | input | 6 | Routing header {dz,dy,dx} |
| flitReq | input | 7 | Requests from the seven input ports for this output |
| injNp | input | 3 | XOR mask applied to the next-port evaluation in this cycle |
| injGrant | input | 7 | XOR mask applied to the grant evaluation in this cycle |
| stall | output | 1 | Stage busy: hold upstream flit and crossbar stage |
| xbarEn | output | 1 | One-cycle pulse enabling crossbar traversal |
| outNp | output | 3 | Final next-port code |
| outGrant | output | 7 | Final one-hot grant |

## Verification
The hardest situations to reach are the mixed ones. One example: the next port disagrees in the compare cycle while the grant agrees, and the grant's third evaluation is then corrupted. Another: the first and third evaluations are both corrupted on different bits, so only the vote recovers the value. The stimulus reaches these through the injection masks, which the bench drives in a chosen cycle relative to acceptance. Each table row carries separate masks for the first, second and third evaluation. Rows are run back to back, so acceptance timing and the recovery stall interleave with the next flit.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  localparam int NUM_PORTS = 7;
  localparam int PORT_W    = $clog2(NUM_PORTS);
  localparam int DIM_W     = 2;
  localparam int NUM_DIMS  = 3;
  localparam int HDR_W     = DIM_W * NUM_DIMS;

  typedef logic [PORT_W-1:0]    port_t;
  typedef logic [NUM_PORTS-1:0] grant_t;
  typedef logic [HDR_W-1:0]     hdr_t;

  localparam port_t PORT_LOCAL = port_t'(0);
  localparam port_t PORT_NORTH = port_t'(1);
  localparam port_t PORT_EAST  = port_t'(2);
  localparam port_t PORT_SOUTH = port_t'(3);
  localparam port_t PORT_WEST  = port_t'(4);
  localparam port_t PORT_UP    = port_t'(5);
  localparam port_t PORT_DOWN  = port_t'(6);

  localparam logic [DIM_W-1:0] DIR_PLUS  = 2'b01;
  localparam logic [DIM_W-1:0] DIR_MINUS = 2'b10;

  typedef enum logic [1:0] {PH_FIRST, PH_CMP, PH_RCV} phase_t;

  typedef struct packed {
    logic loadFirst;
    logic loadSecond;
    logic commitDirect;
    logic commitVoted;
  } strobe_t;

  // R9: dimension order X, Y, Z
  function automatic port_t routeFn(hdr_t hdr);
    logic [DIM_W-1:0] dx, dy, dz;
    dx = hdr[DIM_W-1:0];
    dy = hdr[2*DIM_W-1:DIM_W];
    dz = hdr[3*DIM_W-1:2*DIM_W];
    if (dx == DIR_PLUS)       return PORT_EAST;
    else if (dx == DIR_MINUS) return PORT_WEST;
    else if (dy == DIR_PLUS)  return PORT_NORTH;
    else if (dy == DIR_MINUS) return PORT_SOUTH;
    else if (dz == DIR_PLUS)  return PORT_UP;
    else if (dz == DIR_MINUS) return PORT_DOWN;
    return PORT_LOCAL;
  endfunction

  // R10: fixed priority, lowest index wins
  function automatic grant_t allocFn(grant_t req);
    grant_t g;
    g = '0;
    for (int i = NUM_PORTS - 1; i >= 0; i--) begin
      if (req[i]) begin
        g    = '0;
        g[i] = 1'b1;
      end
    end
    return g;
  endfunction

  function automatic port_t majPort(port_t a, port_t b, port_t c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  function automatic grant_t majGrant(grant_t a, grant_t b, grant_t c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/rsc_compute.sv
module rsc_compute
  import rsc_pkg::*;
(
  input  hdr_t   hdr,
  input  grant_t req,
  input  port_t  injNp,
  input  grant_t injGrant,
  output port_t  np,
  output grant_t grant
);
  // Shared evaluation hardware, reused for every pass of a flit.
  always_comb begin
    np    = routeFn(hdr) ^ injNp;
    grant = allocFn(req) ^ injGrant;
  end
endmodule

// File: rtl/rsc_ctrl.sv
module rsc_ctrl
  import rsc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    flitValid,
  input  logic    npMis,
  input  logic    grantMis,
  output strobe_t strb,
  output logic    stall
);
  phase_t phase, phaseNxt;

  always_comb begin
    strb     = '0;
    phaseNxt = phase;
    case (phase)
      PH_FIRST: begin
        if (flitValid) begin
          strb.loadFirst = 1'b1;
          phaseNxt       = PH_CMP;
        end
      end
      PH_CMP: begin
        if (npMis || grantMis) begin
          strb.loadSecond = 1'b1;
          phaseNxt        = PH_RCV;
        end else begin
          strb.commitDirect = 1'b1;
          phaseNxt          = PH_FIRST;
        end
      end
      PH_RCV: begin
        strb.commitVoted = 1'b1;
        phaseNxt         = PH_FIRST;
      end
      default: phaseNxt = PH_FIRST;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) phase <= PH_FIRST;
    else        phase <= phaseNxt;
  end

  assign stall = (phase != PH_FIRST);

  assert_stall_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && flitValid) |=> stall);
  assert_idle_no_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !flitValid) |=> !stall);
  assert_stall_max_two_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stall) && stall) |=> !stall);
endmodule

// File: rtl/rsc_datapath.sv
module rsc_datapath
  import rsc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  strobe_t strb,
  input  hdr_t    inHdr,
  input  grant_t  inReq,
  input  port_t   injNp,
  input  grant_t  injGrant,
  output logic    npMis,
  output logic    grantMis,
  output port_t   outNp,
  output grant_t  outGrant,
  output logic    xbarEn
);
  hdr_t   heldHdr;
  grant_t heldReq;
  port_t  np1, np2, curNp;
  grant_t gt1, gt2, curGt;
  logic   npBad, gtBad;
  hdr_t   hdrSel;
  grant_t reqSel;

  assign hdrSel = strb.loadFirst ? inHdr : heldHdr;
  assign reqSel = strb.loadFirst ? inReq : heldReq;

  rsc_compute compute_i (
    .hdr     (hdrSel),
    .req     (reqSel),
    .injNp   (injNp),
    .injGrant(injGrant),
    .np      (curNp),
    .grant   (curGt)
  );

  assign npMis    = (curNp != np1);
  assign grantMis = (curGt != gt1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      heldHdr  <= '0;
      heldReq  <= '0;
      np1      <= '0;
      gt1      <= '0;
      np2      <= '0;
      gt2      <= '0;
      npBad    <= 1'b0;
      gtBad    <= 1'b0;
      outNp    <= '0;
      outGrant <= '0;
      xbarEn   <= 1'b0;
    end else begin
      xbarEn <= strb.commitDirect | strb.commitVoted;
      if (strb.loadFirst) begin
        heldHdr <= inHdr;
        heldReq <= inReq;
        np1     <= curNp;
        gt1     <= curGt;
      end
      if (strb.loadSecond) begin
        np2   <= curNp;
        gt2   <= curGt;
        npBad <= npMis;
        gtBad <= grantMis;
      end
      if (strb.commitDirect) begin
        outNp    <= np1;
        outGrant <= gt1;
      end
      if (strb.commitVoted) begin
        outNp    <= npBad ? majPort(np1, np2, curNp) : np1;
        outGrant <= gtBad ? majGrant(gt1, gt2, curGt) : gt1;
      end
    end
  end

  assert_grant_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(outGrant));
  assert_np_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    xbarEn |-> (outNp < port_t'(NUM_PORTS)));
endmodule

// File: rtl/dual_eval_route_stage.sv
module dual_eval_route_stage
  import rsc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       flitValid,
  input  logic [5:0] flitHdr,
  input  logic [6:0] flitReq,
  input  logic [2:0] injNp,
  input  logic [6:0] injGrant,
  output logic       stall,
  output logic       xbarEn,
  output logic [2:0] outNp,
  output logic [6:0] outGrant
);
  strobe_t strb;
  logic    npMis, grantMis;

  rsc_ctrl ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .flitValid(flitValid),
    .npMis    (npMis),
    .grantMis (grantMis),
    .strb     (strb),
    .stall    (stall)
  );

  rsc_datapath dp_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .strb    (strb),
    .inHdr   (flitHdr),
    .inReq   (flitReq),
    .injNp   (injNp),
    .injGrant(injGrant),
    .npMis   (npMis),
    .grantMis(grantMis),
    .outNp   (outNp),
    .outGrant(outGrant),
    .xbarEn  (xbarEn)
  );

  assert_xbar_after_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    xbarEn |-> ($past(stall) && !stall));
endmodule

// File: tb/dual_eval_route_stage_tb.sv
module dual_eval_route_stage_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       flitValid;
  logic [5:0] flitHdr;
  logic [6:0] flitReq;
  logic [2:0] injNp;
  logic [6:0] injGrant;
  logic       stall, xbarEn;
  logic [2:0] outNp;
  logic [6:0] outGrant;

  int testsRun = 0;
  int testsFailed = 0;

  always #10 clk = ~clk;

  dual_eval_route_stage dut_i (
    .clk(clk), .rst_n(rst_n), .flitValid(flitValid), .flitHdr(flitHdr),
    .flitReq(flitReq), .injNp(injNp), .injGrant(injGrant), .stall(stall),
    .xbarEn(xbarEn), .outNp(outNp), .outGrant(outGrant)
  );

  typedef struct packed {
    logic [5:0] hdr;
    logic [6:0] req;
    logic [2:0] np1m; logic [6:0] gt1m;
    logic [2:0] np2m; logic [6:0] gt2m;
    logic [2:0] np3m; logic [6:0] gt3m;
    logic [2:0] expNp; logic [6:0] expGt;
    logic [1:0] lat;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{6'b000001, 7'b0000110, 3'b000, 7'b0, 3'b000, 7'b0, 3'b000, 7'b0, 3'd2, 7'b0000010, 2'd2},
    '{6'b000010, 7'b1000000, 3'b001, 7'b0, 3'b000, 7'b0, 3'b000, 7'b0, 3'd4, 7'b1000000, 2'd3},
    '{6'b000100, 7'b0101000, 3'b000, 7'b0, 3'b000, 7'b0000001, 3'b000, 7'b0, 3'd1, 7'b0001000, 2'd3},
    '{6'b001000, 7'b0000000, 3'b000, 7'b0, 3'b000, 7'b0, 3'b100, 7'b0, 3'd3, 7'b0000000, 2'd2},
    '{6'b010000, 7'b1111111, 3'b010, 7'b0000100, 3'b000, 7'b0, 3'b000, 7'b0, 3'd5, 7'b0000001, 2'd3},
    '{6'b100000, 7'b0010000, 3'b000, 7'b0, 3'b001, 7'b0, 3'b000, 7'b0, 3'd6, 7'b0010000, 2'd3},
    '{6'b000000, 7'b0000001, 3'b000, 7'b0, 3'b000, 7'b0, 3'b000, 7'b0, 3'd0, 7'b0000001, 2'd2},
    '{6'b000101, 7'b0100000, 3'b000, 7'b1000000, 3'b000, 7'b0, 3'b000, 7'b0, 3'd2, 7'b0100000, 2'd3},
    '{6'b011010, 7'b0011000, 3'b000, 7'b0, 3'b000, 7'b0, 3'b000, 7'b0, 3'd4, 7'b0001000, 2'd2},
    '{6'b000011, 7'b0000010, 3'b000, 7'b0, 3'b000, 7'b0, 3'b000, 7'b0, 3'd0, 7'b0000010, 2'd2},
    '{6'b100100, 7'b0000100, 3'b000, 7'b0, 3'b010, 7'b0, 3'b000, 7'b0000100, 3'd1, 7'b0000100, 2'd3},
    '{6'b000001, 7'b0001000, 3'b001, 7'b0, 3'b000, 7'b0, 3'b010, 7'b0, 3'd2, 7'b0001000, 2'd3}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idleInputs();
    flitValid = 1'b0; flitHdr = '0; flitReq = '0; injNp = '0; injGrant = '0;
  endtask

  // Drives at a negedge, returns at the negedge of the xbarEn cycle (R11 back to back)
  task automatic runFlit(input vec_t v, input int idx);
    flitValid = 1'b1; flitHdr = v.hdr; flitReq = v.req;
    injNp = v.np1m; injGrant = v.gt1m;
    @(negedge clk);
    check(stall == 1'b1, "R2 compare-cycle stall", stall, 1);
    check(xbarEn == 1'b0, "R3 no early xbarEn", xbarEn, 0);
    // R8: values driven during stall must not disturb this flit
    flitValid = 1'b1; flitHdr = ~v.hdr; flitReq = ~v.req;
    injNp = v.np2m; injGrant = v.gt2m;
    @(negedge clk);
    if (v.lat == 2'd3) begin
      check(stall == 1'b1 && xbarEn == 1'b0, "R4 recovery stall", {stall, xbarEn}, 2);
      flitValid = 1'b0; injNp = v.np3m; injGrant = v.gt3m;
      @(negedge clk);
    end
    check(xbarEn == 1'b1 && stall == 1'b0, "R3 R4 xbarEn timing", {xbarEn, stall}, 2);
    check(outNp == v.expNp, $sformatf("R5 R9 next port vec%0d", idx), outNp, v.expNp);
    check(outGrant == v.expGt, $sformatf("R6 R10 grant vec%0d", idx), outGrant, v.expGt);
    idleInputs();
    if (v.lat == 2'd2 && (v.np3m != 0 || v.gt3m != 0)) begin
      // R8: mask during idle has no effect
      injNp = v.np3m; injGrant = v.gt3m;
      @(negedge clk);
      check(stall == 1'b0 && xbarEn == 1'b0, "R8 idle injection ignored", {stall, xbarEn}, 0);
      check(outNp == v.expNp, "R8 outputs held", outNp, v.expNp);
      idleInputs();
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    idleInputs();
    repeat (3) @(negedge clk);
    check(stall == 0 && xbarEn == 0 && outNp == 0 && outGrant == 0,
          "R1 reset state", {stall, xbarEn, outNp, outGrant}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      check(stall == 0 && xbarEn == 0, "R7 idle no stall", {stall, xbarEn}, 0);
    end
    for (int i = 0; i < NVEC; i++) runFlit(VECS[i], i);
    @(negedge clk);
    check(stall == 0 && xbarEn == 0, "R8 stall-cycle flit not accepted", {stall, xbarEn}, 0);
    // R11: flit offered while xbarEn is high is taken
    runFlit(VECS[0], 0);
    flitValid = 1'b1; flitHdr = 6'b100000; flitReq = 7'b0000100;
    @(negedge clk);
    check(stall == 1'b1, "R11 accept in xbarEn cycle", stall, 1);
    idleInputs();
    @(negedge clk);
    check(xbarEn == 1 && outNp == 3'd6 && outGrant == 7'b0000100,
          "R11 back-to-back result", {outNp, outGrant}, {3'd6, 7'b0000100});
    // R1: reset mid-flight clears outputs
    rst_n = 1'b0;
    @(negedge clk);
    check(xbarEn == 0 && outNp == 0 && outGrant == 0 && stall == 0,
          "R1 reset clears", {xbarEn, outNp, outGrant}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule